// File: doc/BRIEF.md
# Stack-capable load/store address unit

This unit sits between a small processor's decode stage and a word-organised synchronous data memory. For each memory-class instruction it receives the opcode, the value of the data register, the value of the base register, a register value usable as the offset, and a 16-bit immediate. It forms a byte address and turns that address into a word index by dropping the two low bits. It then drives the memory port and, one cycle later, returns load data and any base-register write-back.

Four access kinds are handled. The first is an indexed load, with either an immediate or a register offset. The second is an indexed store, with the same two offset choices. The third is a pop: it reads at the unmodified base and then hands back base plus offset. The fourth is a push: it lowers the base by the offset and writes the data register at the lowered address. Pop and push therefore each produce a second register write besides the access. The register file sits outside the unit. It is expected to set register 30, the stack pointer, to the memory size in bytes minus one at reset, so that pushes start from the top of memory. Any word index that lies outside the memory depth, and any negative address, raises an error. That error cancels every write the instruction would have made.

Top module: `lsu_stack_unit`

## Requirements
- R1: A load with immediate offset (opcode 32) or register offset (opcode 33) puts word (base+C)/4 on `mem_addr` in the issue cycle. In the following cycle `ld_valid` is 1 and `ld_data` carries that word.
- R2: A store with immediate offset (opcode 36) or register offset (opcode 37) asserts `mem_we` in the issue cycle, with `mem_addr` = (base+C)/4 and `mem_wdata` = the data register value.
- R3: Opcodes 33 and 37 take C from `creg_val`. Opcodes 32, 34, 36 and 38 take C as `imm16` sign-extended to the data width.
- R4: A pop (opcode 34) reads word base/4. In the next cycle `ld_valid` and `base_we` are both 1, with `base_wdata` = base+C.
- R5: A push (opcode 38) writes the data register at word (base−C)/4 in the issue cycle. In the next cycle `base_we` is 1 with `base_wdata` = base−C, and `ld_valid` stays 0.
- R6: If the effective byte address is negative, or its word index is at least the memory depth, `addr_err` is 1 in the next cycle. In that case `mem_we` stays 0 in the issue cycle, and `ld_valid` and `base_we` stay 0 in the next cycle.
- R7: When `req_valid` is 0, or the opcode is none of the six above, `mem_we` stays 0 and no output strobe is raised in the next cycle.
- R8: While `rst_n` is 0, `ld_valid`, `base_we` and `addr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Instruction presented this cycle |
| req_op | input | 6 | Opcode |
| data_val | input | DATA_W | Data register value (store/push source) |
| base_val | input | DATA_W | Base register value |
| creg_val | input | DATA_W | Register offset value for register-offset forms |
| imm16 | input | 16 | Immediate offset |
| mem_addr | output | IDX_W | Word index to memory |
| mem_we | output | 1 | Memory write enable |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after address |
| ld_valid | output | 1 | Load result valid |
| ld_data | output | DATA_W | Load result |
| base_we | output | 1 | Base register write-back enable |
| base_wdata | output | DATA_W | Updated base value |
| addr_err | output | 1 | Address outside memory |

## Verification
Stores and loads with positive and negative immediates, and with register offsets, show whether the two offset sources are chosen correctly and whether C is sign-extended. A push chain from the top of memory, followed by pops, shows whether each kind orders its access and its base update correctly. Accesses just inside and just beyond the last word and below zero show where the range check sits. An out-of-range store whose truncated index would land on word 0, followed by a read of word 0, shows whether the write is really suppressed. A random mix that also contains non-memory opcodes and idle cycles is compared against the behavioural model on every cycle.

// File: rtl/lsu_stack_pkg.sv
package lsu_stack_pkg;

   localparam logic [5:0] OPC_LOAD_IMM  = 6'd32;
   localparam logic [5:0] OPC_LOAD_REG  = 6'd33;
   localparam logic [5:0] OPC_POP_POST  = 6'd34;
   localparam logic [5:0] OPC_STORE_IMM = 6'd36;
   localparam logic [5:0] OPC_STORE_REG = 6'd37;
   localparam logic [5:0] OPC_PUSH_PRE  = 6'd38;

   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_LOAD  = 3'd1,
      K_STORE = 3'd2,
      K_POP   = 3'd3,
      K_PUSH  = 3'd4
   } acc_kind_e;

   typedef struct packed {
      acc_kind_e kind;
      logic      reg_form;
   } acc_dec_t;

   function automatic acc_dec_t decode_op(input logic vld, input logic [5:0] op);
      acc_dec_t d;
      d.kind     = K_NONE;
      d.reg_form = 1'b0;
      if (vld) begin
         case (op)
            OPC_LOAD_IMM:  d.kind = K_LOAD;
            OPC_LOAD_REG:  begin d.kind = K_LOAD;  d.reg_form = 1'b1; end
            OPC_POP_POST:  d.kind = K_POP;
            OPC_STORE_IMM: d.kind = K_STORE;
            OPC_STORE_REG: begin d.kind = K_STORE; d.reg_form = 1'b1; end
            OPC_PUSH_PRE:  d.kind = K_PUSH;
            default:       d.kind = K_NONE;
         endcase
      end
      return d;
   endfunction

endpackage

// File: rtl/lsu_op_decode.sv
module lsu_op_decode
   import lsu_stack_pkg::*;
(
   input  logic       req_valid,
   input  logic [5:0] req_op,
   output acc_kind_e  kind,
   output logic       reg_form,
   output logic       writes_mem,
   output logic       reads_mem
);
   acc_dec_t dec;

   always_comb begin
      dec        = decode_op(req_valid, req_op);
      kind       = dec.kind;
      reg_form   = dec.reg_form;
      writes_mem = (dec.kind == K_STORE) || (dec.kind == K_PUSH);
      reads_mem  = (dec.kind == K_LOAD)  || (dec.kind == K_POP);
   end
endmodule

// File: rtl/lsu_ea_gen.sv
module lsu_ea_gen
   import lsu_stack_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int DEPTH  = 256,
   parameter int IDX_W  = 8
) (
   input  acc_kind_e           kind,
   input  logic                reg_form,
   input  logic [DATA_W-1:0]   base_val,
   input  logic [DATA_W-1:0]   creg_val,
   input  logic [15:0]         imm16,
   output logic [IDX_W-1:0]    word_idx,
   output logic [DATA_W-1:0]   new_base,
   output logic                range_err
);
   localparam int WORD_W = DATA_W - 2;

   logic [DATA_W-1:0] c_val;
   logic [DATA_W-1:0] sum_v;
   logic [DATA_W-1:0] diff_v;
   logic [DATA_W-1:0] ea;
   logic [WORD_W-1:0] word;
   logic              beyond;

   always_comb begin
      c_val  = reg_form ? creg_val : {{(DATA_W-16){imm16[15]}}, imm16};
      sum_v  = base_val + c_val;
      diff_v = base_val - c_val;
      case (kind)
         K_POP:   begin ea = base_val; new_base = sum_v;  end
         K_PUSH:  begin ea = diff_v;   new_base = diff_v; end
         default: begin ea = sum_v;    new_base = sum_v;  end
      endcase
      word = ea[DATA_W-1:2];
   end

   // Range check: bit test for a power-of-two depth, compare otherwise.
   generate
      if (DEPTH == (1 << IDX_W)) begin : g_pow2
         assign beyond = |word[WORD_W-1:IDX_W];
      end else begin : g_cmp
         assign beyond = (word >= WORD_W'(DEPTH));
      end
   endgenerate

   assign range_err = ea[DATA_W-1] | beyond;
   assign word_idx  = word[IDX_W-1:0];
endmodule

// File: rtl/lsu_resp_stage.sv
module lsu_resp_stage
   import lsu_stack_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  acc_kind_e         kind,
   input  logic              reads_mem,
   input  logic              range_err,
   input  logic [DATA_W-1:0] new_base,
   output logic              ld_valid,
   output logic              base_we,
   output logic [DATA_W-1:0] base_wdata,
   output logic              addr_err
);
   logic upd_base;

   assign upd_base = ((kind == K_POP) || (kind == K_PUSH)) && !range_err;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ld_valid   <= 1'b0;
         base_we    <= 1'b0;
         base_wdata <= '0;
         addr_err   <= 1'b0;
      end else begin
         ld_valid <= reads_mem && !range_err;
         base_we  <= upd_base;
         addr_err <= (kind != K_NONE) && range_err;
         if (upd_base) base_wdata <= new_base;
      end
   end
endmodule

// File: rtl/lsu_stack_unit.sv
module lsu_stack_unit
   import lsu_stack_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int MEM_BYTES = 1024,
   parameter int DEPTH     = MEM_BYTES / 4,
   parameter int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [5:0]        req_op,
   input  logic [DATA_W-1:0] data_val,
   input  logic [DATA_W-1:0] base_val,
   input  logic [DATA_W-1:0] creg_val,
   input  logic [15:0]       imm16,
   output logic [IDX_W-1:0]  mem_addr,
   output logic              mem_we,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              ld_valid,
   output logic [DATA_W-1:0] ld_data,
   output logic              base_we,
   output logic [DATA_W-1:0] base_wdata,
   output logic              addr_err
);
   initial begin
      if (MEM_BYTES % 4 != 0)       $fatal(1, "MEM_BYTES must be a multiple of 4");
      if (DATA_W < 16)               $fatal(1, "DATA_W must hold the 16-bit immediate");
      if (IDX_W + 3 > DATA_W)        $fatal(1, "memory too large for DATA_W");
      if ((1 << IDX_W) < DEPTH)      $fatal(1, "IDX_W too small for DEPTH");
   end

   acc_kind_e         kind;
   logic              reg_form;
   logic              writes_mem;
   logic              reads_mem;
   logic              range_err;
   logic [DATA_W-1:0] new_base;

   lsu_op_decode i_dec (
      .req_valid  (req_valid),
      .req_op     (req_op),
      .kind       (kind),
      .reg_form   (reg_form),
      .writes_mem (writes_mem),
      .reads_mem  (reads_mem)
   );

   lsu_ea_gen #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) i_ea (
      .kind      (kind),
      .reg_form  (reg_form),
      .base_val  (base_val),
      .creg_val  (creg_val),
      .imm16     (imm16),
      .word_idx  (mem_addr),
      .new_base  (new_base),
      .range_err (range_err)
   );

   lsu_resp_stage #(.DATA_W(DATA_W)) i_resp (
      .clk        (clk),
      .rst_n      (rst_n),
      .kind       (kind),
      .reads_mem  (reads_mem),
      .range_err  (range_err),
      .new_base   (new_base),
      .ld_valid   (ld_valid),
      .base_we    (base_we),
      .base_wdata (base_wdata),
      .addr_err   (addr_err)
   );

   assign mem_we    = writes_mem && !range_err;
   assign mem_wdata = data_val;
   assign ld_data   = mem_rdata;
endmodule

// File: rtl/lsu_stack_chk.sv
module lsu_stack_chk #(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_valid,
   input logic [5:0]        req_op,
   input logic [IDX_W-1:0]  mem_addr,
   input logic              mem_we,
   input logic              ld_valid,
   input logic              base_we,
   input logic [DATA_W-1:0] base_wdata,
   input logic              addr_err
);
   p_store_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> !addr_err);

   p_err_exclusive_r6: assert property (@(posedge clk) disable iff (!rst_n)
      addr_err |-> (!ld_valid && !base_we));

   p_load_source_r1: assert property (@(posedge clk) disable iff (!rst_n)
      ld_valid |-> ($past(req_valid) &&
                    ($past(req_op) == 6'd32 || $past(req_op) == 6'd33 || $past(req_op) == 6'd34)));

   p_write_source_r2: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> (req_valid && (req_op == 6'd36 || req_op == 6'd37 || req_op == 6'd38)));

   p_push_base_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && req_op == 6'd38) |=>
         (base_we && !ld_valid && base_wdata[IDX_W+1:2] == $past(mem_addr)));

   p_pop_pair_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_valid && base_we) |-> ($past(req_op) == 6'd34));

   p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!ld_valid && !base_we && !addr_err));

   p_reset_low_r8: assert property (@(posedge clk)
      !rst_n |=> (!ld_valid && !base_we && !addr_err));
endmodule

bind lsu_stack_unit lsu_stack_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) i_chk (.*);

// File: tb/test_lsu_stack_unit.sv
module test_lsu_stack_unit;
   localparam int CLK_PERIOD = 10;
   localparam int DATA_W     = 32;
   localparam int MEM_BYTES  = 1024;
   localparam int DEPTH      = MEM_BYTES / 4;
   localparam int IDX_W      = 8;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              req_valid = 1'b0;
   logic [5:0]        req_op = '0;
   logic [DATA_W-1:0] data_val = '0, base_val = '0, creg_val = '0;
   logic [15:0]       imm16 = '0;
   logic [IDX_W-1:0]  mem_addr;
   logic              mem_we;
   logic [DATA_W-1:0] mem_wdata;
   logic [DATA_W-1:0] mem_rdata = '0;
   logic              ld_valid, base_we, addr_err;
   logic [DATA_W-1:0] ld_data, base_wdata;

   lsu_stack_unit #(.DATA_W(DATA_W), .MEM_BYTES(MEM_BYTES)) i_lsu_stack_unit (.*);

   always #(CLK_PERIOD/2) clk = ~clk;

   logic [DATA_W-1:0] bmem [DEPTH];
   always @(posedge clk) begin
      if (mem_we) bmem[mem_addr] <= mem_wdata;
      mem_rdata <= bmem[mem_addr];
   end

   int ref_mem [DEPTH];
   int n_cmp = 0, n_bad = 0;
   bit done = 0;

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // One cycle: drive at negedge, check port-side write, then registered results.
   task automatic issue(bit vld, int op, int dv, int bv, int cv, int iv);
      int  c, ea, nb, widx;
      bit  ld, st, pop, psh, err, regf, kind_ok;
      int  exp_ld;
      req_valid = vld; req_op = op[5:0]; data_val = dv; base_val = bv;
      creg_val = cv; imm16 = iv[15:0];
      ld  = vld && (op == 32 || op == 33);
      st  = vld && (op == 36 || op == 37);
      pop = vld && op == 34;
      psh = vld && op == 38;
      kind_ok = ld || st || pop || psh;
      regf = (op == 33 || op == 37);
      c  = regf ? cv : int'($signed(iv[15:0]));           // R3
      ea = bv + c; nb = bv + c;
      if (pop) ea = bv;
      if (psh) begin ea = bv - c; nb = bv - c; end
      widx = ea >>> 2;
      err  = (ea < 0) || (widx >= DEPTH);
      #1;
      chk("R2/R5/R6/R7 mem_we", mem_we, (st || psh) && !err);
      if ((st || psh) && !err) begin
         chk("R2 mem_addr", mem_addr, widx[IDX_W-1:0]);
         chk("R2 mem_wdata", mem_wdata, dv);
      end
      if ((ld || pop) && !err) begin
         chk("R1 mem_addr", mem_addr, widx[IDX_W-1:0]);
         exp_ld = ref_mem[widx];
      end
      if ((st || psh) && !err) ref_mem[widx] = dv;
      @(negedge clk);
      chk("R1/R4/R6/R7 ld_valid", ld_valid, (ld || pop) && !err);
      if ((ld || pop) && !err) chk("R1 ld_data", ld_data, exp_ld);
      chk("R4/R5/R6 base_we", base_we, (pop || psh) && !err);
      if ((pop || psh) && !err) chk("R4/R5 base_wdata", base_wdata, nb);
      chk("R6 addr_err", addr_err, kind_ok && err);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      int sp;
      foreach (bmem[i]) begin bmem[i] = '0; ref_mem[i] = 0; end
      repeat (3) @(negedge clk);
      chk("R8 ld_valid reset", ld_valid, 0);
      chk("R8 base_we reset", base_we, 0);
      chk("R8 addr_err reset", addr_err, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2/R1: immediate store and load, positive and negative offsets
      issue(1, 36, 32'h1111_0001, 100, 0, 8);
      issue(1, 32, 0, 100, 0, 8);
      issue(1, 36, 32'h2222_0002, 200, 0, -16);
      issue(1, 32, 0, 180, 0, 4);
      // R3: register-offset forms ignore imm16
      issue(1, 37, 32'h3333_0003, 40, 60, 16'h7FFC);
      issue(1, 33, 0, 0, 100, 16'h8000);
      // boundary: last word valid, next beyond (R6)
      issue(1, 36, 32'hCAFE_F00D, 1020, 0, 3);
      issue(1, 32, 0, 1000, 0, 20);
      issue(1, 32, 0, 1024, 0, 0);
      issue(1, 32, 0, 0, 0, -4);
      // R6: suppressed store whose truncated index is word 0
      issue(1, 36, 32'hDEAD_BEEF, 1024, 0, 0);
      issue(1, 32, 0, 0, 0, 0);
      issue(1, 38, 32'h5, 2, 0, 4);      // push below zero
      // R5/R4: push chain from top of memory, then pops
      sp = MEM_BYTES - 1;
      for (int k = 0; k < 4; k++) begin
         issue(1, 38, 32'hA000_0000 + k, sp, 0, 4);
         sp -= 4;
      end
      for (int k = 0; k < 4; k++) begin
         issue(1, 34, 0, sp, 0, 4);
         sp += 4;
      end
      // R7: idle and non-memory opcodes
      issue(0, 36, 32'h77, 8, 0, 0);
      issue(1, 0, 32'h77, 8, 0, 0);
      issue(1, 35, 32'h77, 8, 0, 0);
      issue(1, 32, 0, 8, 0, 0);
      // random mix
      for (int k = 0; k < 600; k++) begin
         int ops [10] = '{32, 33, 34, 36, 37, 38, 0, 39, 35, 63};
         int op = ops[$urandom_range(0, 9)];
         int bv = $urandom_range(0, 1100) - 40;
         int cv = $urandom_range(0, 160) - 80;
         int iv = $urandom_range(0, 160) - 80;
         issue($urandom_range(0, 7) != 0, op, $urandom, bv, cv, iv);
      end
      issue(0, 0, 0, 0, 0, 0);
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule